// File: doc/BRIEF.md
# Three-Channel Edge-Skew Detector

This block measures how far apart in time three already-sliced and synchronised 1-bit channel signals rise. The channels are red, green and blue. They are compared in a ring of three pairs: red against green, green against blue, and blue against red. In each pair the first member is the "lead candidate" (A) and the second is the "follower" (B).

For each pair, a small state machine emits a pulse for the time between the two rising edges. The pulse goes out on `pulse_up` when A rises first and on `pulse_dn` when B rises first. A measurement counts only when both signals of the pair are high together. If the leading signal drops before the other one rises, the event is marked bad and discarded.

Each valid event adds its signed width, in system-clock cycles, to a saturating per-pair accumulator. A per-pair event counter raises `meas_valid` once enough valid events have been gathered. A controller reads the accumulators to choose delay settings for the three paths.

The per-pair state machine has four states:
- SETTLE: wait for both signals low. This is the reset state.
- ARMED: wait for the first rise.
- A_LEAD: A is high and B has not risen yet.
- B_LEAD: B is high and A has not risen yet.

The transitions are:
- SETTLE→ARMED when both signals are low.
- ARMED→A_LEAD on A alone.
- ARMED→B_LEAD on B alone.
- ARMED→SETTLE when both rise in the same cycle (a zero-width valid event).
- A_LEAD→SETTLE when B rises (valid) or A falls (bad).
- B_LEAD→SETTLE when A rises (valid) or B falls (bad).

Top module: `rgb_skew_detector`

## Requirements
- R1: Channel bits are `chan_in[0]`=red, `chan_in[1]`=green, `chan_in[2]`=blue. Pair 0 compares red (A) with green (B), pair 1 compares green (A) with blue (B), and pair 2 compares blue (A) with red (B). Pair p's accumulator is `skew_acc[p*ACC_W +: ACC_W]`.
- R2: When A is sampled high while B is low from ARMED, `pulse_up[p]` is high from the next cycle until the clock edge that samples B high. Its width in cycles equals the rise-to-rise skew.
- R3: When B leads A, `pulse_dn[p]` behaves symmetrically and `pulse_up[p]` stays low.
- R4: When A and B are first sampled high on the same edge, the result is a valid event of width 0 and no pulse is produced.
- R5: If the leading signal is sampled low before the other signal is sampled high, `bad_event[p]` is high for exactly one cycle after that edge. The accumulator and the event count are left unchanged.
- R6: After any event, and after reset, a pair does not start a new measurement until both of its signals have been sampled low together.
- R7: A valid event adds +width (A led) or −width (B led) to the pair's signed accumulator. The new value is visible in the cycle after the closing edge.
- R8: The accumulator saturates at 2^(ACC_W-1)−1 and at −2^(ACC_W-1) instead of wrapping.
- R9: `acc_clear` sampled high zeros all accumulators and event counts on the next cycle. It takes priority over an event closing on the same edge.
- R10: `meas_valid[p]` is high whenever the number of valid events since the last clear or reset is at least `event_target`. The count saturates at 2^CNT_W−1.
- R11: While `rst_n` is low, all pulses, bad flags and accumulators are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_in | input | 3 | Sliced channel levels: bit 0 red, bit 1 green, bit 2 blue |
| acc_clear | input | 1 | Synchronous clear of accumulators and event counts |
| event_target | input | CNT_W | Valid events needed before `meas_valid` rises |
| pulse_up | output | 3 | Per pair: A leads, pulse spans the skew |
| pulse_dn | output | 3 | Per pair: B leads, pulse spans the skew |
| bad_event | output | 3 | Per pair: one-cycle strobe for a non-overlapping event |
| meas_valid | output | 3 | Per pair: enough valid events accumulated |
| skew_acc | output | 3*ACC_W | Three signed saturating skew sums, pair 0 in the low bits |

## Verification
The bench goes after the following corner cases, and what a wrong design would do in each:
- Simultaneous rises: a detector with a one-cycle bias would add a spurious ±1.
- A leader that drops before the follower rises: a careless design would accumulate a bogus width or count it toward `meas_valid`.
- A follower that toggles while the leader stays high: a design that does not wait for both signals low would re-arm and double-count.
- Long skews driven twice in each direction: these push the accumulator into both saturation limits, where a wrapping adder flips sign.
- A clear landing on the same edge as a closing event: a design with the wrong priority leaves a non-zero sum.

// File: rtl/skew_pkg.sv
package skew_pkg;
    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_ARMED  = 2'd1,
        ST_A_LEAD = 2'd2,
        ST_B_LEAD = 2'd3
    } pair_state_t;
endpackage

// File: rtl/skew_pair_fsm.sv
module skew_pair_fsm
    import skew_pkg::*;
#(
    parameter int RUN_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_in,
    input  logic             b_in,
    output logic             pulse_up,
    output logic             pulse_dn,
    output logic             ev_ok,
    output logic             ev_bad,
    output logic             ev_neg,
    output logic [RUN_W-1:0] ev_width
);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    pair_state_t state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d  = state_q;
        run_d    = run_q;
        ev_ok    = 1'b0;
        ev_bad   = 1'b0;
        ev_neg   = 1'b0;
        ev_width = '0;
        pulse_up = 1'b0;
        pulse_dn = 1'b0;
        unique case (state_q)
            ST_SETTLE: begin
                if (!a_in && !b_in) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (a_in && b_in) begin
                    ev_ok   = 1'b1;
                    state_d = ST_SETTLE;
                end else if (a_in) begin
                    run_d   = {{(RUN_W-1){1'b0}}, 1'b1};
                    state_d = ST_A_LEAD;
                end else if (b_in) begin
                    run_d   = {{(RUN_W-1){1'b0}}, 1'b1};
                    state_d = ST_B_LEAD;
                end
            end
            ST_A_LEAD: begin
                pulse_up = 1'b1;
                ev_width = run_q;
                if (!a_in) begin
                    ev_bad  = 1'b1;
                    state_d = ST_SETTLE;
                end else if (b_in) begin
                    ev_ok   = 1'b1;
                    state_d = ST_SETTLE;
                end else if (run_q != RUN_MAX) begin
                    run_d = run_q + 1'b1;
                end
            end
            ST_B_LEAD: begin
                pulse_dn = 1'b1;
                ev_neg   = 1'b1;
                ev_width = run_q;
                if (!b_in) begin
                    ev_bad  = 1'b1;
                    state_d = ST_SETTLE;
                end else if (a_in) begin
                    ev_ok   = 1'b1;
                    state_d = ST_SETTLE;
                end else if (run_q != RUN_MAX) begin
                    run_d = run_q + 1'b1;
                end
            end
            default: state_d = ST_SETTLE;
        endcase
    end

    // R2
    up_needs_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_up |-> $past(a_in));
    // R3
    dn_needs_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_dn |-> $past(b_in));
    // R6
    rearm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ok || ev_bad) |=> (!pulse_up && !pulse_dn));
endmodule

// File: rtl/skew_accum.sv
module skew_accum #(
    parameter int ACC_W = 16,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               ev_ok,
    input  logic               ev_bad,
    input  logic               ev_neg,
    input  logic [ACC_W-2:0]   ev_width,
    input  logic [CNT_W-1:0]   target,
    output logic [ACC_W-1:0]   acc,
    output logic               meas_valid,
    output logic               bad_evt
);
    localparam logic signed [ACC_W:0] SUM_MAX = $signed({2'b00, {(ACC_W-1){1'b1}}});
    localparam logic signed [ACC_W:0] SUM_MIN = $signed({2'b11, {(ACC_W-1){1'b0}}});
    localparam logic [CNT_W-1:0]      CNT_MAX = {CNT_W{1'b1}};

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             bad_q;
    logic signed [ACC_W:0] delta, sum;
    logic [ACC_W-1:0] sat_sum;

    always_comb begin
        delta = $signed({2'b00, ev_width});
        if (ev_neg) delta = -delta;
        sum = $signed({acc_q[ACC_W-1], acc_q}) + delta;
        if (sum > SUM_MAX)      sat_sum = SUM_MAX[ACC_W-1:0];
        else if (sum < SUM_MIN) sat_sum = SUM_MIN[ACC_W-1:0];
        else                    sat_sum = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
            bad_q <= 1'b0;
        end else begin
            bad_q <= ev_bad;
            if (clr) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (ev_ok) begin
                acc_q <= sat_sum;
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign acc        = acc_q;
    assign bad_evt    = bad_q;
    assign meas_valid = (cnt_q >= target);

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0 && cnt_q == '0));
    // R5
    bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bad && !clr) |=> ($stable(acc_q) && $stable(cnt_q)));
    // R7
    up_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ok && !ev_neg && !clr) |=> ($signed(acc_q) >= $signed($past(acc_q))));
    // R10
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/rgb_skew_detector.sv
module rgb_skew_detector #(
    parameter int ACC_W = 16,
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         chan_in,
    input  logic               acc_clear,
    input  logic [CNT_W-1:0]   event_target,
    output logic [2:0]         pulse_up,
    output logic [2:0]         pulse_dn,
    output logic [2:0]         bad_event,
    output logic [2:0]         meas_valid,
    output logic [3*ACC_W-1:0] skew_acc
);
    localparam int NPAIR = 3;
    localparam int RUN_W = ACC_W - 1;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic             ev_ok, ev_bad, ev_neg;
        logic [RUN_W-1:0] ev_width;

        skew_pair_fsm #(.RUN_W(RUN_W)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_in     (chan_in[p]),
            .b_in     (chan_in[(p + 1) % NPAIR]),
            .pulse_up (pulse_up[p]),
            .pulse_dn (pulse_dn[p]),
            .ev_ok    (ev_ok),
            .ev_bad   (ev_bad),
            .ev_neg   (ev_neg),
            .ev_width (ev_width)
        );

        skew_accum #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (acc_clear),
            .ev_ok      (ev_ok),
            .ev_bad     (ev_bad),
            .ev_neg     (ev_neg),
            .ev_width   (ev_width),
            .target     (event_target),
            .acc        (skew_acc[p*ACC_W +: ACC_W]),
            .meas_valid (meas_valid[p]),
            .bad_evt    (bad_event[p])
        );
    end
endmodule

// File: tb/tb_rgb_skew_detector.sv
module tb_rgb_skew_detector;
    localparam int AW = 8;
    localparam int CW = 4;
    localparam int AMAX = 127;
    localparam int AMIN = -128;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [2:0]      chan_in;
    logic            acc_clear;
    logic [CW-1:0]   event_target;
    logic [2:0]      pulse_up, pulse_dn, bad_event, meas_valid;
    logic [3*AW-1:0] skew_acc;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference: 0 settle, 1 armed, 2 A leading, 3 B leading
    int mst[3], mrun[3], macc[3], mcnt[3], mbad[3];

    rgb_skew_detector #(.ACC_W(AW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .acc_clear(acc_clear),
        .event_target(event_target), .pulse_up(pulse_up), .pulse_dn(pulse_dn),
        .bad_event(bad_event), .meas_valid(meas_valid), .skew_acc(skew_acc)
    );

    always #5 clk = ~clk;

    function automatic int acc_of(int p);
        return int'($signed(skew_acc[p*AW +: AW]));
    endfunction

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        for (int p = 0; p < 3; p++) begin
            int a, b, ok, w;
            a = chan_in[p];
            b = chan_in[(p + 1) % 3];
            if (!rst_n) begin
                mst[p] = 0; mrun[p] = 0; macc[p] = 0; mcnt[p] = 0; mbad[p] = 0;
            end else begin
                ok = 0; w = 0; mbad[p] = 0;
                if (mst[p] == 0) begin
                    if (!a && !b) mst[p] = 1;
                end else if (mst[p] == 1) begin
                    if (a && b) begin ok = 1; mst[p] = 0; end
                    else if (a) begin mst[p] = 2; mrun[p] = 1; end
                    else if (b) begin mst[p] = 3; mrun[p] = 1; end
                end else begin
                    int lead, other;
                    lead  = (mst[p] == 2) ? a : b;
                    other = (mst[p] == 2) ? b : a;
                    if (!lead) begin mbad[p] = 1; mst[p] = 0; end
                    else if (other) begin
                        ok = 1;
                        w = (mst[p] == 2) ? mrun[p] : -mrun[p];
                        mst[p] = 0;
                    end else if (mrun[p] < AMAX) mrun[p]++;
                end
                if (acc_clear) begin
                    macc[p] = 0; mcnt[p] = 0;
                end else if (ok) begin
                    macc[p] = macc[p] + w;
                    if (macc[p] > AMAX) macc[p] = AMAX;
                    if (macc[p] < AMIN) macc[p] = AMIN;
                    if (mcnt[p] < 15) mcnt[p]++;
                end
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int p = 0; p < 3; p++) begin
                chk("R2 pulse_up", pulse_up[p], mst[p] == 2);
                chk("R3 pulse_dn", pulse_dn[p], mst[p] == 3);
                chk("R5 bad_event", bad_event[p], mbad[p]);
                chk("R7 skew_acc", acc_of(p), macc[p]);
                chk("R10 meas_valid", meas_valid[p], mcnt[p] >= int'(event_target));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic clear_all();
        acc_clear = 1'b1; step(1); acc_clear = 1'b0; step(1);
    endtask

    task automatic lead_event(logic [2:0] first, logic [2:0] both, int gap);
        chan_in = first; step(gap);
        chan_in = both;  step(2);
        chan_in = 3'b000; step(3);
    endtask

    initial begin
        rst_n = 1'b0; chan_in = 3'b000; acc_clear = 1'b0; event_target = 4'd2;
        step(3);
        // R11 reset state
        chk("R11 acc0", acc_of(0), 0);
        chk("R11 pulses", {29'd0, pulse_up | pulse_dn}, 0);
        chk("R11 bad", {29'd0, bad_event}, 0);
        rst_n = 1'b1; step(2);

        // R2 red leads green by 3
        lead_event(3'b001, 3'b011, 3);
        chk("R2 acc0 red lead", acc_of(0), 3);

        // R3 green leads red by 5
        lead_event(3'b010, 3'b011, 5);
        chk("R3 acc0 green lead", acc_of(0), -2);
        chk("R10 valid after 2", meas_valid[0], 1);

        // R4 simultaneous rise
        chan_in = 3'b111; step(1);
        chk("R4 no pulse", {29'd0, pulse_up | pulse_dn}, 0);
        step(1);
        chk("R4 zero width", acc_of(0), -2);
        chan_in = 3'b000; step(3);

        // R5 leader drops before follower
        chan_in = 3'b001; step(2);
        chan_in = 3'b000; step(1);
        chk("R5 bad strobe", bad_event[0], 1);
        step(1);
        chk("R5 bad one cycle", bad_event[0], 0);
        step(1);
        chk("R5 acc unchanged", acc_of(0), -2);

        // R6 follower toggles while leader stays high
        chan_in = 3'b011; step(2);
        chan_in = 3'b001; step(2);
        chan_in = 3'b011; step(1);
        chk("R6 no rearm pulse", pulse_up[0], 0);
        step(1);
        chk("R6 acc unchanged", acc_of(0), -2);
        chan_in = 3'b000; step(3);

        // R9 clear, R8 saturation both ways
        clear_all();
        chk("R9 acc cleared", acc_of(0), 0);
        chk("R9 valid cleared", meas_valid[0], 0);
        lead_event(3'b001, 3'b011, 100);
        lead_event(3'b001, 3'b011, 100);
        chk("R8 positive limit", acc_of(0), AMAX);
        clear_all();
        lead_event(3'b010, 3'b011, 100);
        lead_event(3'b010, 3'b011, 100);
        chk("R8 negative limit", acc_of(0), AMIN);

        // R9 clear on the same edge as a closing event
        chan_in = 3'b001; step(4);
        chan_in = 3'b011; acc_clear = 1'b1; step(1);
        acc_clear = 1'b0; step(1);
        chk("R9 clear wins", acc_of(0), 0);
        chan_in = 3'b000; step(3);

        // R10 event target
        clear_all();
        event_target = 4'd3;
        for (int k = 0; k < 2; k++) begin
            chan_in = 3'b011; step(2); chan_in = 3'b000; step(2);
        end
        chk("R10 below target", meas_valid[0], 0);
        chan_in = 3'b011; step(2); chan_in = 3'b000; step(2);
        chk("R10 at target", meas_valid[0], 1);

        // R1 ring pairing
        clear_all();
        lead_event(3'b100, 3'b101, 2);
        chk("R1 blue vs red", acc_of(2), 2);
        chk("R1 red vs green untouched", acc_of(0), 0);
        chk("R1 green vs blue untouched", acc_of(1), 0);
        lead_event(3'b010, 3'b110, 4);
        chk("R1 green vs blue", acc_of(1), 4);

        step(5);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule